// File: doc/BRIEF.md
# Latched Flash Status Register

This block keeps the status byte of a flash-style memory and drives it onto a 16-bit read word. An internal write engine supplies a level that reports whether it is idle. It also supplies single-cycle pulses that raise four sticky error flags. The flags stay raised until the command decoder sends a clear pulse.

The read word does not follow the live status. It comes from a snapshot register that loads on each falling edge of either active-low strobe, chip enable or output enable. A status change that happens after the snapshot stays hidden until a strobe is toggled again. When the two strobes fall at different times, the later fall provides the value that is read. The strobes are sampled on the system clock, and an edge is found by comparing each strobe with its value from the previous cycle.

Top module: `flash_status_latch`

## Requirements
- R1: Bit 7 of the captured word is 1 when `eng_idle` was high at the capture edge, and 0 when it was low.
- R2: A one-cycle pulse on `err_lock_set`, `err_vpp_set`, `err_prog_set` or `err_erase_set` sets status bit 1, 3, 4 or 5 respectively. The bit stays set after the pulse ends.
- R3: A `clr_sticky` pulse returns bits 1, 3, 4 and 5 to 0. If a set pulse arrives in the same cycle as the clear, the clear wins.
- R4: Bits 15:8 of `status_word` always read 0, and bits 0, 2 and 6 always read 0.
- R5: At the first clock edge that samples a strobe low after it was sampled high, the snapshot loads the status held at that edge. The new value appears on `status_word` right after that edge. Either strobe can trigger the load.
- R6: If one strobe falls and the other falls later, the second fall reloads the snapshot, so the later value is the one read.
- R7: Without a fresh falling strobe edge, `status_word` does not change. This holds across status changes and across rising strobe edges.
- R8: After reset, `status_word` is 0000h and all sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_idle | input | 1 | Write engine idle level (ready bit source) |
| err_lock_set | input | 1 | Pulse: block lock error |
| err_vpp_set | input | 1 | Pulse: program-voltage error |
| err_prog_set | input | 1 | Pulse: program error |
| err_erase_set | input | 1 | Pulse: erase error |
| clr_sticky | input | 1 | Pulse: clear all sticky flags |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| status_word | output | 16 | Captured status word |

## Verification
A set or clear pulse reaches the sticky flags at the clock edge that follows it. It only becomes visible after a later falling strobe, which loads the snapshot at its own sampling edge. The bench therefore drives every input on the falling clock edge. It queues the expected word when it drives a strobe fall, and the monitor compares one time unit after the next rising edge, which is the first moment the new snapshot can appear. Hold checks are queued without a strobe fall and sampled at the same point, so any load that should not happen is caught.

// File: rtl/flash_status_latch.sv
module flash_status_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_idle,
  input  logic              err_lock_set,
  input  logic              err_vpp_set,
  input  logic              err_prog_set,
  input  logic              err_erase_set,
  input  logic              clr_sticky,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [WORD_W-1:0] status_word
);
  localparam int STAT_W = 8;
  localparam int PAD_W  = WORD_W - STAT_W;

  logic [3:0]        sticky_q;
  logic [3:0]        set_vec;
  logic              ce_q, oe_q;
  logic              grab;
  logic [STAT_W-1:0] live;
  logic [STAT_W-1:0] snap_q;

  assign set_vec = {err_erase_set, err_prog_set, err_vpp_set, err_lock_set};
  assign live    = {eng_idle, 1'b0, sticky_q[3], sticky_q[2], sticky_q[1], 1'b0, sticky_q[0], 1'b0};
  assign grab    = (ce_q & ~ce_n) | (oe_q & ~oe_n);
  assign status_word = {{PAD_W{1'b0}}, snap_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sticky_q <= '0;
    else if (clr_sticky) sticky_q <= '0;
    else                 sticky_q <= sticky_q | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      snap_q <= '0;
    end else begin
      ce_q <= ce_n;
      oe_q <= oe_n;
      if (grab) snap_q <= live;
    end
  end

  // R1
  ready_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> status_word[7] == $past(eng_idle));

  // R5
  snapshot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> status_word[STAT_W-1:0] == $past(live));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grab |=> $stable(status_word));

  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sticky |=> sticky_q == 4'b0000);

  // R2
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_sticky |=> (($past(sticky_q) & ~sticky_q) == 4'b0000));

  // R4
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[WORD_W-1:STAT_W] == '0 && status_word[6] == 1'b0 &&
    status_word[2] == 1'b0 && status_word[0] == 1'b0);
endmodule

// File: tb/test_flash_status_latch.sv
module test_flash_status_latch;
  logic clk = 0, rst_n = 0;
  logic eng_idle = 0, e_lock = 0, e_vpp = 0, e_prog = 0, e_erase = 0, clr = 0;
  logic ce_n = 1, oe_n = 1;
  logic [15:0] status_word;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] q_val[$];
  string       q_tag[$];
  event        chk_ev;
  logic m_lock = 0, m_vpp = 0, m_prog = 0, m_erase = 0;

  always #5 clk = ~clk;

  flash_status_latch i_flash_status_latch (
    .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle),
    .err_lock_set(e_lock), .err_vpp_set(e_vpp), .err_prog_set(e_prog),
    .err_erase_set(e_erase), .clr_sticky(clr), .ce_n(ce_n), .oe_n(oe_n),
    .status_word(status_word));

  function automatic logic [15:0] model();
    return {8'h00, eng_idle, 1'b0, m_erase, m_prog, m_vpp, 1'b0, m_lock, 1'b0};
  endfunction

  task automatic pulse(input logic l, v, p, e, c);
    @(negedge clk);
    e_lock = l; e_vpp = v; e_prog = p; e_erase = e; clr = c;
    if (c) begin m_lock = 0; m_vpp = 0; m_prog = 0; m_erase = 0; end
    else begin m_lock |= l; m_vpp |= v; m_prog |= p; m_erase |= e; end
    @(negedge clk);
    e_lock = 0; e_vpp = 0; e_prog = 0; e_erase = 0; clr = 0;
  endtask

  task automatic push_and_wait(input logic [15:0] v, input string tag);
    q_val.push_back(v); q_tag.push_back(tag);
    @(posedge clk); #1; ->chk_ev; #1;
  endtask

  task automatic read_both(input string tag);
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk); ce_n = 0; oe_n = 0;
    push_and_wait(model(), tag);
  endtask

  task automatic hold_check(input logic [15:0] v, input string tag);
    @(negedge clk);
    push_and_wait(v, tag);
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q_val.size() > 0) begin
        logic [15:0] ev;
        string t;
        ev = q_val.pop_front(); t = q_tag.pop_front();
        n_chk++;
        if (status_word !== ev) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, status_word, ev);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    hold_check(16'h0000, "R8 reset word");
    eng_idle = 1;
    read_both("R1 idle ready");
    read_both("R8 sticky clear after reset");
    eng_idle = 0;
    read_both("R1 busy");
    eng_idle = 1;
    pulse(0, 0, 1, 0, 0);
    read_both("R2 prog flag");
    pulse(1, 0, 0, 0, 0);
    pulse(0, 1, 0, 1, 0);
    read_both("R2 R4 all flags");
    @(negedge clk); ce_n = 1; oe_n = 1;
    hold_check(16'h00BA, "R7 rising strobes");
    eng_idle = 0;
    pulse(0, 0, 0, 0, 1);
    hold_check(16'h00BA, "R7 no toggle after change");
    eng_idle = 1;
    read_both("R3 clear");
    pulse(1, 1, 1, 1, 0);
    read_both("R2 set again");
    pulse(1, 0, 1, 0, 1);
    read_both("R3 clear beats set");
    // R6: ce falls first, then oe falls later
    eng_idle = 0;
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk); ce_n = 0;
    push_and_wait(model(), "R5 ce fall");
    pulse(0, 0, 0, 1, 0);
    eng_idle = 1;
    @(negedge clk); oe_n = 0;
    push_and_wait(model(), "R6 later oe fall");
    // R5: oe alone, ce held high
    @(negedge clk); ce_n = 1; oe_n = 1;
    eng_idle = 0;
    @(negedge clk); oe_n = 0;
    push_and_wait(model(), "R5 oe only");
    hold_check(16'h0020, "R7 strobes held low");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule